// File: doc/BRIEF.md
# GPIO Port with Independent Pullup Control

This block controls one 8-bit bidirectional port. Each pin has a direction bit, an output value bit and a pullup bit, each held in its own register. The pullup register is separate from the other two. Writing the output value or the direction never switches a pullup on or off. A pin can therefore keep its pullup while it is an input, an output driven high, or an output driven low. The block drives three vectors towards the pads: output-enable, output value and pullup-enable. It also gives back the pad levels through a synchroniser.

One control bit, shared by the whole port, turns on a break-before-make guard. When the guard is on, a pin whose direction changes from input to output stays tristated for one extra clock before it drives. When several pins switch in the same write, they all sit in that gap in the same cycle. A change from output to input always releases the pin at once.

Each pin runs a small state machine with three states. PIN_IN means the pin is tristated as an input. PIN_GAP is the one-clock tristated hold. PIN_DRIVE means the pad is driven. The transitions are:
- to_drive: PIN_IN to PIN_DRIVE, when the direction becomes output and the guard is off.
- to_gap: PIN_IN to PIN_GAP, when the direction becomes output and the guard is on.
- gap_done: PIN_GAP to PIN_DRIVE, when the direction is still output.
- gap_abort: PIN_GAP to PIN_IN, when the direction has returned to input.
- release: PIN_DRIVE to PIN_IN, when the direction becomes input.

Every other case keeps the current state.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it, pad_oe, pad_out and pad_pull are all 0x00, in_sync is 0x00, and the guard is off.
- R2: A write to the pullup register appears on pad_pull in the cycle after the write edge. Bit i of pull_wdata set to 1 enables the pullup of pin i.
- R3: Writes to the output or direction registers leave pad_pull unchanged, including when a pin is an input and its output bit is written to 1.
- R4: A pin with its pullup enabled keeps pad_pull at 1 while it is an output driven low.
- R5: A write to the output register appears on pad_out in the cycle after the write edge.
- R6: With the guard off, a pin whose direction bit is written from 0 (input) to 1 (output) has pad_oe at 1 in the cycle after the write edge.
- R7: With the guard on, a pin whose direction bit is written from 0 to 1 keeps pad_oe at 0 for exactly one cycle after the write edge, then drives. If its direction returns to 0 during that cycle, it never drives.
- R8: A pin whose direction bit is written to 0 has pad_oe at 0 in the cycle after the write edge, whatever the guard setting.
- R9: All pins that switch from input to output in one guarded write are held tristated in the same single cycle and start driving together.
- R10: in_sync equals the pad_in value sampled two clock edges earlier.
- R11: The guard is bit bbm_wdata, loaded on bbm_we. It applies to direction writes made in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_we | input | 1 | Write strobe for the direction register |
| dir_wdata | input | 8 | New direction bits (1 = output) |
| out_we | input | 1 | Write strobe for the output register |
| out_wdata | input | 8 | New output levels |
| pull_we | input | 1 | Write strobe for the pullup register |
| pull_wdata | input | 8 | New pullup enables (1 = on) |
| bbm_we | input | 1 | Write strobe for the guard bit |
| bbm_wdata | input | 1 | New guard setting (1 = on) |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| pad_pull | output | 8 | Pad pullup enables |
| in_sync | output | 8 | Synchronised pad levels |

## Verification
Register results are due one clock after the write edge:
- pad_out and pad_pull show the written value.
- pad_oe rises (guard off) or falls (any guard setting).

A guarded input-to-output change is due two clocks after the write edge. Readback of the pad levels is due two clocks after they change. The bench drives inputs on falling edges and updates its behavioural model on each rising edge. It compares every output against that model at the next falling edge, so each result is checked exactly in the cycle it is due. Directed checks sample at those same falling edges to pin down the gap cycle and the synchroniser delay.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        PIN_IN    = 2'd0,
        PIN_GAP   = 2'd1,
        PIN_DRIVE = 2'd2
    } pin_state_t;

endpackage

// File: rtl/gpio_pin_fsm.sv
module gpio_pin_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_nx,
    input  logic bbm_on,
    output logic oe
);

    pin_state_t state_q;
    pin_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IN: begin
                if (dir_nx) state_d = bbm_on ? PIN_GAP : PIN_DRIVE;
            end
            PIN_GAP: begin
                state_d = dir_nx ? PIN_DRIVE : PIN_IN;
            end
            PIN_DRIVE: begin
                if (!dir_nx) state_d = PIN_IN;
            end
            default: state_d = PIN_IN;
        endcase
    end

    always_comb begin
        oe = (state_q == PIN_DRIVE);
    end

    // R7: the tristated hold lasts one cycle only
    a_r7_gap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_GAP) |=> (state_q != PIN_GAP));

    // R7: a guarded switch to output holds the pin off first
    a_r7_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe && state_q != PIN_GAP && dir_nx && bbm_on) |=> !oe);

    // R6: with the guard off the pin drives on the next cycle
    a_r6_direct_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_IN && dir_nx && !bbm_on) |=> oe);

    // R8: a switch to input releases at once
    a_r8_release_now: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_nx |=> !oe);

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic [WIDTH-1:0] dir_wdata,
    input  logic             out_we,
    input  logic [WIDTH-1:0] out_wdata,
    input  logic             pull_we,
    input  logic [WIDTH-1:0] pull_wdata,
    input  logic             bbm_we,
    input  logic             bbm_wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pull,
    output logic [WIDTH-1:0] in_sync
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dir_nx;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pull_q;
    logic             bbm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            pull_q <= '0;
            bbm_q  <= 1'b0;
        end else begin
            if (dir_we)  dir_q  <= dir_wdata;
            if (out_we)  out_q  <= out_wdata;
            if (pull_we) pull_q <= pull_wdata;
            if (bbm_we)  bbm_q  <= bbm_wdata;
        end
    end

    always_comb begin
        dir_nx = dir_we ? dir_wdata : dir_q;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            gpio_pin_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .dir_nx (dir_nx[i]),
                .bbm_on (bbm_q),
                .oe     (pad_oe[i])
            );
        end
    endgenerate

    gpio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    assign pad_out  = out_q;
    assign pad_pull = pull_q;

    logic [CNT_W-1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    since_rst_q <= '0;
        else if (since_rst_q != CNT_W'(SYNC_STAGES))   since_rst_q <= since_rst_q + 1'b1;
    end

    // R3: the pullup moves only on its own strobe
    a_r3_pull_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_we |=> $stable(pad_pull));

    // R2: the pullup write lands one cycle later
    a_r2_pull_load: assert property (@(posedge clk) disable iff (!rst_n)
        pull_we |=> (pad_pull == $past(pull_wdata)));

    // R5: the output value write lands one cycle later
    a_r5_out_load: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> (pad_out == $past(out_wdata)));

    // R10: readback lags the pads by two edges
    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            a_r10_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst_q == CNT_W'(2)) |-> (in_sync == $past(pad_in, 2)));
        end
    endgenerate

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_we = 1'b0, out_we = 1'b0, pull_we = 1'b0, bbm_we = 1'b0;
    logic [7:0] dir_wdata = '0, out_wdata = '0, pull_wdata = '0;
    logic       bbm_wdata = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pull, in_sync;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n),
        .dir_we(dir_we), .dir_wdata(dir_wdata),
        .out_we(out_we), .out_wdata(out_wdata),
        .pull_we(pull_we), .pull_wdata(pull_wdata),
        .bbm_we(bbm_we), .bbm_wdata(bbm_wdata),
        .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull), .in_sync(in_sync)
    );

    // behavioural reference
    bit [7:0] m_dir, m_out, m_pull, m_oe, m_wait;
    bit       m_bbm;
    bit [7:0] m_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_pull = 0; m_oe = 0; m_wait = 0; m_bbm = 0;
            m_hist.delete();
        end else begin
            bit [7:0] nd;
            nd = dir_we ? dir_wdata : m_dir;
            for (int i = 0; i < 8; i++) begin
                if (!nd[i]) begin
                    m_oe[i] = 0; m_wait[i] = 0;
                end else if (!m_oe[i]) begin
                    if (m_wait[i]) begin m_oe[i] = 1; m_wait[i] = 0; end
                    else if (m_bbm) m_wait[i] = 1;
                    else m_oe[i] = 1;
                end
            end
            m_dir = nd;
            if (out_we)  m_out  = out_wdata;
            if (pull_we) m_pull = pull_wdata;
            if (bbm_we)  m_bbm  = bbm_wdata;
            m_hist.push_back(pad_in);
            if (m_hist.size() > 2) void'(m_hist.pop_front());
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(cur_req, "pad_oe",   pad_oe,   m_oe);
        chk(cur_req, "pad_out",  pad_out,  m_out);
        chk(cur_req, "pad_pull", pad_pull, m_pull);
        chk("R10",   "in_sync",  in_sync,  (m_hist.size() == 2) ? m_hist[0] : 8'h00);
    end

    task automatic wr_dir(logic [7:0] v);
        dir_we = 1; dir_wdata = v; @(negedge clk); dir_we = 0;
    endtask
    task automatic wr_out(logic [7:0] v);
        out_we = 1; out_wdata = v; @(negedge clk); out_we = 0;
    endtask
    task automatic wr_pull(logic [7:0] v);
        pull_we = 1; pull_wdata = v; @(negedge clk); pull_we = 0;
    endtask
    task automatic wr_bbm(logic v);
        bbm_we = 1; bbm_wdata = v; @(negedge clk); bbm_we = 0;
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset oe", pad_oe, 8'h00);
        chk("R1", "reset pull", pad_pull, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "post-reset out", pad_out, 8'h00);

        cur_req = "R2"; wr_pull(8'hA5);
        chk("R2", "pull load", pad_pull, 8'hA5);

        cur_req = "R3"; wr_out(8'hFF);
        chk("R3", "pull after out write", pad_pull, 8'hA5);
        chk("R5", "out load", pad_out, 8'hFF);

        cur_req = "R6"; wr_dir(8'h0F);
        chk("R6", "direct drive", pad_oe, 8'h0F);
        chk("R3", "pull after dir write", pad_pull, 8'hA5);

        cur_req = "R4"; wr_out(8'h00);
        chk("R4", "pull on while driving low", pad_pull, 8'hA5);

        cur_req = "R11"; wr_bbm(1'b1);
        cur_req = "R9"; wr_dir(8'hFF);
        chk("R7", "gap cycle", pad_oe, 8'h0F);
        @(negedge clk);
        chk("R9", "all drive together", pad_oe, 8'hFF);

        cur_req = "R8"; wr_dir(8'h00);
        chk("R8", "release under guard", pad_oe, 8'h00);

        cur_req = "R7"; wr_dir(8'h01);
        chk("R7", "held off", pad_oe, 8'h00);
        wr_dir(8'h00);
        chk("R7", "aborted gap", pad_oe, 8'h00);
        @(negedge clk);
        chk("R7", "still off", pad_oe, 8'h00);

        cur_req = "R11";
        bbm_we = 1; bbm_wdata = 0; dir_we = 1; dir_wdata = 8'h10;
        @(negedge clk); bbm_we = 0; dir_we = 0;
        chk("R11", "guard applies until written", pad_oe, 8'h00);
        @(negedge clk);
        chk("R11", "then drives", pad_oe, 8'h10);
        wr_dir(8'h30);
        chk("R11", "guard now off", pad_oe, 8'h30);

        cur_req = "R10"; pad_in = 8'h3C;
        @(negedge clk);
        chk("R10", "one edge", in_sync, 8'h00);
        @(negedge clk);
        chk("R10", "two edges", in_sync, 8'h3C);

        cur_req = "R9";
        for (int n = 0; n < 400; n++) begin
            dir_we = $urandom_range(0, 2) == 0; dir_wdata = 8'($urandom);
            out_we = $urandom_range(0, 1) == 0; out_wdata = 8'($urandom);
            pull_we = $urandom_range(0, 3) == 0; pull_wdata = 8'($urandom);
            bbm_we = $urandom_range(0, 5) == 0; bbm_wdata = 1'($urandom);
            pad_in = 8'($urandom);
            @(negedge clk);
        end
        dir_we = 0; out_we = 0; pull_we = 0; bbm_we = 0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule